// File: doc/BRIEF.md
# SMI Status and Mask Register

This block is a 64-bit control and status register that gathers system-management interrupt sources. There are five sources. The first is an error source, formed from any of a set of device error lines on the interconnect, including the controller's own line. The second is a debug event. The third is a strobe raised when a monitored power-count register is written. The fourth is a strobe raised when a monitored power-level register is read. The fifth is the SMI flag taken from the most recently received serial packet.

Each source has a mask bit in the low field of the register. A mask bit at 0 enables its source. The register also holds one status bit per source. The error, debug, power-count and power-level status bits are sticky, and software clears them by writing 1 to them. The packet status bit is different. It is a live copy of the last packet's flag, and software cannot write it.

The error, debug and packet sources are asynchronous-class sources and drive an asynchronous SMI request. The two power-management sources drive a synchronous SMI request. Software accesses the register through a plain read/write strobe port. Read data returns one cycle after the read strobe.

Top module: `smi_ctl_reg`

## Requirements
- R1: After reset the register reads 0x0000_0000_0000_001F, and both request outputs are 0.
- R2: A write loads bits 4:0 as masks. The order, from bit 0 upward, is error, debug, power-count, power-level, packet. A mask bit of 0 enables its source.
- R3: Status bits 16 (error), 17 (debug), 18 (power-count) and 19 (power-level) become 1 at the clock edge that samples their event, but only if that source's mask bit is 0 before the edge. A masked event leaves the bit unchanged.
- R4: Writing 1 to any of bits 19:16 clears that status bit. Writing 0 to one of those bits leaves it unchanged.
- R5: When an enabled event and a write-one-to-clear hit the same status bit at the same edge, the bit ends up at 1.
- R6: Bit 20 takes the value of `pkt_smi` at every edge where `pkt_valid` is 1, and keeps its value at all other edges. Register writes and the mask bits have no effect on it.
- R7: `asmi_req` is 1 exactly when at least one of these holds: bit 16 is set with mask bit 0 clear, bit 17 is set with mask bit 1 clear, or bit 20 is set with mask bit 4 clear.
- R8: `ssmi_req` is 1 exactly when bit 18 or bit 19 is set.
- R9: Bits 15:5 and 63:21 always read as 0, and writes to them have no effect.
- R10: The edge that samples `reg_rd` loads `reg_rdata` with the register contents as they were before that edge. When `reg_rd` was 0 at that edge, `reg_rdata` is 0.
- R11: Any single bit of `err_lines` counts as the error event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after `reg_rd` |
| err_lines | input | N_ERR_LINES | Device error lines, OR-combined into the error source |
| dbg_evt | input | 1 | Debug event |
| cnt_wr_evt | input | 1 | Power-count register write strobe |
| lvl_rd_evt | input | 1 | Power-level register read strobe |
| pkt_valid | input | 1 | A serial packet has been received |
| pkt_smi | input | 1 | SMI flag of that packet |
| asmi_req | output | 1 | Asynchronous SMI request |
| ssmi_req | output | 1 | Synchronous SMI request |

## Verification
Every result is due one clock edge after its stimulus. This covers a status bit set by an event, a bit cleared by a write, the packet bit that follows a received packet, and the read data that follows a strobe. The two request outputs are combinational from register state, so they move at that same edge. The bench drives all inputs on the falling edge and compares the outputs on the next falling edge. Its reference model is advanced once per cycle in the same order, so each comparison falls exactly one rising edge after the stimulus it depends on.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int REG_W    = 64;
    localparam int NSRC     = 5;
    localparam int NSTICKY  = 4;
    localparam int MASK_LSB = 0;
    localparam int STAT_LSB = 16;
    localparam int EXT_POS  = STAT_LSB + NSTICKY;

    typedef enum int unsigned {
        SRC_ERR = 0,
        SRC_DBG = 1,
        SRC_CNT = 2,
        SRC_LVL = 3,
        SRC_EXT = 4
    } src_e;

    // class membership per source index
    localparam logic [NSRC-1:0] ASYNC_CLASS = 5'b10011;
    localparam logic [NSRC-1:0] SYNC_CLASS  = 5'b01100;
    localparam logic [NSRC-1:0] MASK_RESET  = '1;
endpackage

// File: rtl/smi_sticky_bit.sv
module smi_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;   // event has priority over clear
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/smi_mask_reg.sv
module smi_mask_reg
    import smi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [NSRC-1:0] wmask_i,
    output logic [NSRC-1:0] mask_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_o <= MASK_RESET;
        else if (wr_i) mask_o <= wmask_i;
    end
endmodule

// File: rtl/smi_req_gen.sv
module smi_req_gen
    import smi_pkg::*;
(
    input  logic [NSRC-1:0] stat_i,
    input  logic [NSRC-1:0] mask_i,
    output logic            asmi_o,
    output logic            ssmi_o
);
    always_comb begin
        asmi_o = |(stat_i & ~mask_i & ASYNC_CLASS);
        ssmi_o = |(stat_i & SYNC_CLASS);
    end
endmodule

// File: rtl/smi_ctl_reg.sv
module smi_ctl_reg
    import smi_pkg::*;
#(
    parameter int N_ERR_LINES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_rd,
    input  logic                   reg_wr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic [N_ERR_LINES-1:0] err_lines,
    input  logic                   dbg_evt,
    input  logic                   cnt_wr_evt,
    input  logic                   lvl_rd_evt,
    input  logic                   pkt_valid,
    input  logic                   pkt_smi,
    output logic                   asmi_req,
    output logic                   ssmi_req
);
    logic [NSRC-1:0]    mask_q;
    logic [NSTICKY-1:0] stat_q;
    logic [NSTICKY-1:0] ev_vec;
    logic               ext_q;
    logic [REG_W-1:0]   img;

    always_comb begin
        ev_vec          = '0;
        ev_vec[SRC_ERR] = |err_lines;
        ev_vec[SRC_DBG] = dbg_evt;
        ev_vec[SRC_CNT] = cnt_wr_evt;
        ev_vec[SRC_LVL] = lvl_rd_evt;
    end

    smi_mask_reg u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr),
        .wmask_i(reg_wdata[MASK_LSB +: NSRC]),
        .mask_o (mask_q)
    );

    for (genvar g = 0; g < NSTICKY; g++) begin : g_sticky
        smi_sticky_bit u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(ev_vec[g] & ~mask_q[g]),
            .clr_i(reg_wr & reg_wdata[STAT_LSB + g]),
            .q_o  (stat_q[g])
        );
    end

    // live copy of the last packet flag, not software writable
    always_ff @(posedge clk) begin
        if (!rst_n)         ext_q <= 1'b0;
        else if (pkt_valid) ext_q <= pkt_smi;
    end

    always_comb begin
        img                          = '0;
        img[MASK_LSB +: NSRC]        = mask_q;
        img[STAT_LSB +: NSTICKY]     = stat_q;
        img[EXT_POS]                 = ext_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= img;
        else             reg_rdata <= '0;
    end

    smi_req_gen u_req (
        .stat_i({ext_q, stat_q}),
        .mask_i(mask_q),
        .asmi_o(asmi_req),
        .ssmi_o(ssmi_req)
    );
endmodule

// File: rtl/smi_ctl_reg_chk.sv
module smi_ctl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_rd,
    input logic        reg_wr,
    input logic [63:0] reg_wdata,
    input logic [63:0] reg_rdata,
    input logic        dbg_evt,
    input logic        cnt_wr_evt,
    input logic        lvl_rd_evt,
    input logic        pkt_valid,
    input logic        pkt_smi,
    input logic        asmi_req,
    input logic        ssmi_req,
    input logic [4:0]  mask_q,
    input logic [3:0]  stat_q,
    input logic        ext_q
);
    p_set_dbg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_evt && !mask_q[1]) |=> stat_q[1]);

    p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[1] && !stat_q[1]) |=> !stat_q[1]);

    p_w1c_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[18] && !(cnt_wr_evt && !mask_q[2])) |=> !stat_q[2]);

    p_ext_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> (ext_q == $past(pkt_smi)));

    p_ext_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> $stable(ext_q));

    p_async_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[0] && mask_q[1] && mask_q[4]) |-> !asmi_req);

    p_sync_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssmi_req) |-> $past(cnt_wr_evt || lvl_rd_evt));

    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[15:5] == '0) && (reg_rdata[63:21] == '0));

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));
endmodule

bind smi_ctl_reg smi_ctl_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dbg_evt   (dbg_evt),
    .cnt_wr_evt(cnt_wr_evt),
    .lvl_rd_evt(lvl_rd_evt),
    .pkt_valid (pkt_valid),
    .pkt_smi   (pkt_smi),
    .asmi_req  (asmi_req),
    .ssmi_req  (ssmi_req),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .ext_q     (ext_q)
);

// File: tb/smi_ctl_reg_bench.sv
module smi_ctl_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NERR       = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            reg_rd, reg_wr;
    logic [63:0]     reg_wdata;
    logic [63:0]     reg_rdata;
    logic [NERR-1:0] err_lines;
    logic            dbg_evt, cnt_wr_evt, lvl_rd_evt, pkt_valid, pkt_smi;
    logic            asmi_req, ssmi_req;

    int n_vec  = 0;
    int n_fail = 0;

    // reference model state
    logic [4:0] m_mask;
    logic [3:0] m_st;
    logic       m_ext;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_ctl_reg #(.N_ERR_LINES(NERR)) u_smi_ctl_reg (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_lines(err_lines),
        .dbg_evt(dbg_evt), .cnt_wr_evt(cnt_wr_evt), .lvl_rd_evt(lvl_rd_evt),
        .pkt_valid(pkt_valid), .pkt_smi(pkt_smi),
        .asmi_req(asmi_req), .ssmi_req(ssmi_req)
    );

    function automatic logic [63:0] model_img(logic [4:0] mk, logic [3:0] st, logic ex);
        logic [63:0] v = '0;
        v[4:0]   = mk;
        v[19:16] = st;
        v[20]    = ex;
        return v;
    endfunction

    function automatic logic exp_asmi(logic [4:0] mk, logic [3:0] st, logic ex);
        return (st[0] & ~mk[0]) | (st[1] & ~mk[1]) | (ex & ~mk[4]);
    endfunction

    function automatic logic exp_ssmi(logic [3:0] st);
        return st[2] | st[3];
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s rdata act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check1(string tag, string what, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
        end
    endtask

    // called at a falling edge: drive, update model, check at next falling edge
    task automatic step(string tag, logic rd, logic wr, logic [63:0] wd,
                        logic [NERR-1:0] el, logic dbg, logic cnt, logic lvl,
                        logic pv, logic ps);
        logic [63:0] e_rd;
        logic [3:0]  ev, setv, clrv;
        reg_rd = rd; reg_wr = wr; reg_wdata = wd; err_lines = el;
        dbg_evt = dbg; cnt_wr_evt = cnt; lvl_rd_evt = lvl;
        pkt_valid = pv; pkt_smi = ps;
        e_rd = rd ? model_img(m_mask, m_st, m_ext) : 64'h0;
        ev   = {lvl, cnt, dbg, |el};
        setv = ev & ~m_mask[3:0];
        clrv = wr ? wd[19:16] : 4'h0;
        m_st = setv | (m_st & ~clrv);
        if (wr) m_mask = wd[4:0];
        if (pv) m_ext = ps;
        @(negedge clk);
        check64(tag, reg_rdata, e_rd);
        check1(tag, "asmi_req", asmi_req, exp_asmi(m_mask, m_st, m_ext));
        check1(tag, "ssmi_req", ssmi_req, exp_ssmi(m_st));
    endtask

    task automatic rd_only(string tag);
        step(tag, 1'b1, 1'b0, 64'h0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_rd = 0; reg_wr = 0; reg_wdata = '0; err_lines = '0;
        dbg_evt = 0; cnt_wr_evt = 0; lvl_rd_evt = 0; pkt_valid = 0; pkt_smi = 0;
        m_mask = 5'h1F; m_st = '0; m_ext = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R1: reset image is 0x1F, requests low
        rd_only("R1");
        // R3: masked events leave status clear
        step("R3", 1'b0, 1'b0, 64'h0, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        rd_only("R3");
        // R2 R9: clear masks, attempt reserved writes
        step("R9", 1'b0, 1'b1, 64'hFFFF_FFFF_FFF0_FFE0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_only("R2");
        // R11 R7: single error line raises async request
        step("R11", 1'b0, 1'b0, 64'h0, 4'b0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R3 R8: debug and power events
        step("R8", 1'b0, 1'b0, 64'h0, '0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        rd_only("R3");
        // R4: writing 0 leaves status
        step("R4", 1'b0, 1'b1, 64'h0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_only("R4");
        // R5: event beats clear
        step("R5", 1'b0, 1'b1, 64'h0001_0000, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_only("R5");
        // R4: clear error and debug
        step("R4", 1'b0, 1'b1, 64'h0003_0000, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_only("R4");
        // R6: packet flag, write has no effect, masking gates only the request
        step("R6", 1'b0, 1'b0, 64'h0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        step("R6", 1'b0, 1'b1, 64'h0010_0000, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_only("R6");
        step("R7", 1'b0, 1'b1, 64'h0000_0010, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rd_only("R7");
        step("R6", 1'b0, 1'b0, 64'h0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        rd_only("R6");
        // R10: read strobe low gives zero data
        step("R10", 1'b0, 1'b0, 64'h0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // random mix for R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] wd;
            logic        wr;
            wd = {$urandom(), $urandom()};
            wr = ($urandom() % 6) == 0;
            step("R3/R4/R7/R8/R10", ($urandom() % 2) == 0, wr, wd,
                 (($urandom() % 5) == 0) ? NERR'($urandom()) : '0,
                 ($urandom() % 5) == 0, ($urandom() % 5) == 0,
                 ($urandom() % 5) == 0, ($urandom() % 4) == 0,
                 ($urandom() % 2) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule